// File: doc/BRIEF.md
# Shared SRAM Access Arbiter for an ISA Host

This block lets an external ISA bus master read and write a 32K x 8 static RAM that a local 8-bit CPU normally owns. A memory read or write on the ISA bus counts as an access only when its address falls in the RAM's assigned window. When such an access starts, the ready line is pulled low at once, with no clock involved, so the ISA cycle stalls. The request is then synchronized to the system clock. A one-cycle blip on a strobe is filtered out.

To take the local buses, the arbiter raises the CPU's tri-state control line. The CPU lets its address, data and R/W lines float only after the next falling edge of its E clock. For this reason the arbiter watches a synchronized copy of E and waits for a fall that occurred after the request was raised. Once the buses are free it enables the ISA address buffers. Next it runs the RAM strobes and the data buffer controls. A read ends with a latch pulse into the ISA read register. A write ends with the write strobe rising while the chip is still selected. The ready line returns high as the last step.

The arbiter keeps the buses until both ISA strobes have gone inactive. It then drops the address buffers and the tri-state request, and the CPU resumes.

Top module: `shram_isa_arbiter`

## Requirements
- R1: An access is recognised only when memr_ni or memw_ni is low and isa_addr_i[19:15] equals the window base bits (default 5'b11010, addresses 0xD0000 to 0xD7FFF). Outside the window, iochrdy_o stays high and cpu_tsc_o stays low.
- R2: For a recognised access, iochrdy_o goes low in the same time step as the strobe, before any clock edge.
- R3: A strobe pulse seen by at most one system clock edge never raises cpu_tsc_o.
- R4: isa_abuf_en_o rises only after cpu_tsc_o has been high across a falling edge of e_clk_i. It is high only while cpu_tsc_o is high.
- R5: isa_abuf_en_o rises before sram_ce_no falls. sram_ce_no is low only while isa_abuf_en_o is high.
- R6: On a read, sram_oe_no and rd_buf_oe_no are low during the RAM phase. rd_buf_clk_o pulses once while the chip is selected and output-enabled, before iochrdy_o rises. The latched byte equals the RAM contents at the address.
- R7: On a write, sram_we_no and wr_buf_oe_no are low during the RAM phase. sram_we_no rises while sram_ce_no is still low, and it never goes low together with sram_oe_no. sram_we_no is high again before isa_abuf_en_o falls. The byte is stored at the address.
- R8: iochrdy_o stays low while the chip is selected during a recognised access. It rises only after the RAM phase has ended.
- R9: After both strobes go high, isa_abuf_en_o and cpu_tsc_o drop within a few cycles. The next access is served normally.
- R10: After reset with no strobe active: cpu_tsc_o=0, isa_abuf_en_o=0, sram_ce_no=sram_oe_no=sram_we_no=1, rd_buf_oe_no=wr_buf_oe_no=1, rd_buf_clk_o=0, iochrdy_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| isa_addr_i | input | 20 | ISA address |
| memr_ni | input | 1 | ISA memory read strobe, active low |
| memw_ni | input | 1 | ISA memory write strobe, active low |
| e_clk_i | input | 1 | CPU E clock, asynchronous to clk_i |
| iochrdy_o | output | 1 | ISA ready; low stalls the ISA cycle |
| cpu_tsc_o | output | 1 | CPU tri-state request, active high |
| isa_abuf_en_o | output | 1 | ISA address buffer enable, active high |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write strobe, active low |
| rd_buf_oe_no | output | 1 | ISA read data buffer output enable, active low |
| rd_buf_clk_o | output | 1 | ISA read latch clock, rising edge captures |
| wr_buf_oe_no | output | 1 | ISA write data buffer output enable, active low |

## Verification
On every cycle, the bound assertions check the ordering rules between the outputs. These rules are: a chip select only under the address buffers, the buffers only under the tri-state request, the read clock only inside a selected read, and no overlap of write strobe and output enable. They also check that ready stays high outside a recognised access and low while the chip is selected, and that the write strobe is off before the buffers drop. Some behaviour only the bench scenarios can show. These are the combinational stall in the strobe's own time step, the rejection of a strobe blip, and waiting for a real E-clock fall after the request (against a bench CPU model that floats its buses only then). The same goes for data integrity across random reads and writes.

// File: rtl/shram_arb_pkg.sv
package shram_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_REQ_BUS,
    ST_WAIT_E_FALL,
    ST_ADDR_EN,
    ST_MEM_ACCESS,
    ST_READY,
    ST_RELEASE
  } arb_state_e;
endpackage

// File: rtl/shram_sync.sv
module shram_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/shram_fall_det.sv
module shram_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_s, lvl_prev_q;

  shram_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lvl_i),
    .q_o   (lvl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= 1'b0;
    else         lvl_prev_q <= lvl_s;
  end

  assign fall_o = lvl_prev_q & ~lvl_s;
endmodule

// File: rtl/shram_seq_fsm.sv
module shram_seq_fsm
  import shram_arb_pkg::*;
#(
  parameter int SYNC_LAT = 2,
  parameter int ACC_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rd_i,
  input  logic e_fall_i,
  output logic tsc_o,
  output logic abuf_en_o,
  output logic ce_o,
  output logic oe_o,
  output logic we_o,
  output logic rd_oe_o,
  output logic rd_clk_o,
  output logic wr_oe_o,
  output logic ready_o
);
  localparam int CNT_MAX = (SYNC_LAT > ACC_CYC) ? SYNC_LAT : ACC_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LAT_END = CW'(SYNC_LAT - 1);
  localparam logic [CW-1:0] ACC_END = CW'(ACC_CYC - 1);

  arb_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic rd_q, rd_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    rd_d    = rd_q;
    unique case (state_q)
      ST_IDLE:        if (req_i) state_d = ST_SYNC;
      ST_SYNC: begin
        // a strobe seen for one edge only falls back here
        if (req_i) begin
          state_d = ST_REQ_BUS;
          rd_d    = rd_i;
        end else state_d = ST_IDLE;
      end
      ST_REQ_BUS: begin
        // let falls already in the E synchronizer drain
        if (cnt_q == LAT_END) state_d = ST_WAIT_E_FALL;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_WAIT_E_FALL: if (e_fall_i) state_d = ST_ADDR_EN;
      ST_ADDR_EN:     state_d = ST_MEM_ACCESS;
      ST_MEM_ACCESS: begin
        if (cnt_q == ACC_END) state_d = ST_READY;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_READY:       if (!req_i) state_d = ST_RELEASE;
      ST_RELEASE:     state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
    end
  end

  logic in_mem, last_mem;
  assign in_mem   = (state_q == ST_MEM_ACCESS);
  assign last_mem = in_mem && (cnt_q == ACC_END);

  assign tsc_o     = state_q inside {ST_REQ_BUS, ST_WAIT_E_FALL, ST_ADDR_EN,
                                     ST_MEM_ACCESS, ST_READY};
  assign abuf_en_o = state_q inside {ST_ADDR_EN, ST_MEM_ACCESS, ST_READY};
  assign ce_o      = in_mem;
  assign oe_o      = in_mem && rd_q;
  assign we_o      = in_mem && !rd_q && !last_mem;
  assign rd_oe_o   = rd_q && (in_mem || state_q == ST_READY);
  assign rd_clk_o  = last_mem && rd_q;
  assign wr_oe_o   = in_mem && !rd_q;
  assign ready_o   = (state_q == ST_READY);
endmodule

// File: rtl/shram_isa_arbiter.sv
module shram_isa_arbiter #(
  parameter int          ISA_AW   = 20,
  parameter int          SRAM_AW  = 15,
  parameter logic [19:0] WIN_BASE = 20'hD0000,
  parameter int          STAGES   = 2,
  parameter int          ACC_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ISA_AW-1:0] isa_addr_i,
  input  logic              memr_ni,
  input  logic              memw_ni,
  input  logic              e_clk_i,
  output logic              iochrdy_o,
  output logic              cpu_tsc_o,
  output logic              isa_abuf_en_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic              rd_buf_oe_no,
  output logic              rd_buf_clk_o,
  output logic              wr_buf_oe_no
);
  localparam int WIN_W = ISA_AW - SRAM_AW;
  localparam logic [WIN_W-1:0] WIN_TAG = WIN_BASE[ISA_AW-1:SRAM_AW];

  logic in_win, acc_valid, req_s, e_fall;
  logic ce, oe, we, rd_oe, wr_oe, ready;

  assign in_win    = (isa_addr_i[ISA_AW-1:SRAM_AW] == WIN_TAG);
  assign acc_valid = in_win && (!memr_ni || !memw_ni);

  shram_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (acc_valid),
    .q_o   (req_s)
  );

  shram_fall_det #(.STAGES(STAGES)) u_e_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (e_clk_i),
    .fall_o(e_fall)
  );

  shram_seq_fsm #(.SYNC_LAT(STAGES), .ACC_CYC(ACC_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_s),
    .rd_i     (!memr_ni),
    .e_fall_i (e_fall),
    .tsc_o    (cpu_tsc_o),
    .abuf_en_o(isa_abuf_en_o),
    .ce_o     (ce),
    .oe_o     (oe),
    .we_o     (we),
    .rd_oe_o  (rd_oe),
    .rd_clk_o (rd_buf_clk_o),
    .wr_oe_o  (wr_oe),
    .ready_o  (ready)
  );

  // stall is combinational on the strobe; release only from the ready state
  assign iochrdy_o    = !acc_valid || ready;
  assign sram_ce_no   = !ce;
  assign sram_oe_no   = !oe;
  assign sram_we_no   = !we;
  assign rd_buf_oe_no = !rd_oe;
  assign wr_buf_oe_no = !wr_oe;
endmodule

// File: rtl/shram_arb_checker.sv
module shram_arb_checker #(
  parameter int          ISA_AW   = 20,
  parameter int          SRAM_AW  = 15,
  parameter logic [19:0] WIN_BASE = 20'hD0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ISA_AW-1:0] isa_addr_i,
  input logic              memr_ni,
  input logic              memw_ni,
  input logic              iochrdy_o,
  input logic              cpu_tsc_o,
  input logic              isa_abuf_en_o,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic              rd_buf_clk_o
);
  logic hit;
  assign hit = (isa_addr_i[ISA_AW-1:SRAM_AW] == WIN_BASE[ISA_AW-1:SRAM_AW])
               && (!memr_ni || !memw_ni);

  p_no_stall_outside_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> iochrdy_o);
  p_abuf_under_tsc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isa_abuf_en_o |-> cpu_tsc_o);
  p_abuf_after_tsc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isa_abuf_en_o) |-> $past(cpu_tsc_o));
  p_ce_under_abuf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> isa_abuf_en_o);
  p_rdclk_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_buf_clk_o |-> (!sram_ce_no && !sram_oe_no));
  p_we_oe_apart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_no && !sram_oe_no));
  p_we_off_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(isa_abuf_en_o) |-> $past(sram_we_no));
  p_hold_in_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !sram_ce_no) |-> !iochrdy_o);
endmodule

bind shram_isa_arbiter shram_arb_checker #(
  .ISA_AW(ISA_AW), .SRAM_AW(SRAM_AW), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .isa_addr_i   (isa_addr_i),
  .memr_ni      (memr_ni),
  .memw_ni      (memw_ni),
  .iochrdy_o    (iochrdy_o),
  .cpu_tsc_o    (cpu_tsc_o),
  .isa_abuf_en_o(isa_abuf_en_o),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .rd_buf_clk_o (rd_buf_clk_o)
);

// File: tb/shram_isa_arbiter_test.sv
module shram_isa_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] isa_addr_i = 20'h00000;
  logic        memr_ni = 1'b1, memw_ni = 1'b1;
  logic        e_clk_i = 1'b0;
  logic iochrdy_o, cpu_tsc_o, isa_abuf_en_o, sram_ce_no, sram_oe_no, sram_we_no;
  logic rd_buf_oe_no, rd_buf_clk_o, wr_buf_oe_no;

  shram_isa_arbiter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .isa_addr_i(isa_addr_i),
    .memr_ni(memr_ni), .memw_ni(memw_ni), .e_clk_i(e_clk_i),
    .iochrdy_o(iochrdy_o), .cpu_tsc_o(cpu_tsc_o), .isa_abuf_en_o(isa_abuf_en_o),
    .sram_ce_no(sram_ce_no), .sram_oe_no(sram_oe_no), .sram_we_no(sram_we_no),
    .rd_buf_oe_no(rd_buf_oe_no), .rd_buf_clk_o(rd_buf_clk_o),
    .wr_buf_oe_no(wr_buf_oe_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  initial begin
    #2;
    forever #35 e_clk_i = ~e_clk_i;
  end

  int n_chk = 0, n_bad = 0;
  logic [7:0] sram_mem [256];
  logic [7:0] ref_mem  [256];
  logic [7:0] isa_wdata = 8'h00;
  logic [7:0] rd_latch;
  logic cpu_float = 1'b0;
  logic viol_r4 = 0, viol_r5 = 0, viol_r6 = 0, viol_r7 = 0;
  int   rdclk_cnt = 0;

  // bench CPU: buses float only after an E fall seen with the request high
  always @(negedge e_clk_i or negedge cpu_tsc_o)
    cpu_float <= (cpu_tsc_o === 1'b1) && !e_clk_i;

  always @(posedge rd_buf_clk_o)
    rd_latch <= (!sram_ce_no && !sram_oe_no && isa_abuf_en_o) ? sram_mem[isa_addr_i[7:0]] : 8'hxx;

  always @(posedge sram_we_no)
    if (sram_ce_no === 1'b0 && isa_abuf_en_o && wr_buf_oe_no === 1'b0)
      sram_mem[isa_addr_i[7:0]] <= isa_wdata;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (isa_abuf_en_o && !cpu_float) viol_r4 <= 1'b1;
      if (!sram_ce_no && !isa_abuf_en_o) viol_r5 <= 1'b1;
      if (!sram_oe_no && rd_buf_oe_no) viol_r6 <= 1'b1;
      if (!sram_we_no && wr_buf_oe_no) viol_r7 <= 1'b1;
      if (rd_buf_clk_o) rdclk_cnt <= rdclk_cnt + 1;
    end
  end

  function automatic logic in_window(input logic [19:0] a);
    return a[19:15] == 5'b11010;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (iochrdy_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_access(input logic [19:0] a, input bit rd, input logic [7:0] wd);
    bit ok;
    int rc0;
    viol_r4 = 0; viol_r5 = 0; viol_r6 = 0; viol_r7 = 0;
    rc0 = rdclk_cnt;
    tick(1);
    isa_addr_i = a;
    isa_wdata  = wd;
    if (rd) memr_ni = 1'b0; else memw_ni = 1'b0;
    #1;
    check(iochrdy_o == 1'b0, "R2", "ready low in strobe time step", iochrdy_o, 0);
    wait_ready(ok);
    check(ok, "R8", "ready returns", ok, 1);
    check(sram_ce_no == 1'b1, "R8", "chip deselected at ready", sram_ce_no, 1);
    check(!viol_r4, "R4", "buffers only after E fall under request", viol_r4, 0);
    check(!viol_r5, "R5", "select only under address buffers", viol_r5, 0);
    if (rd) begin
      check(rdclk_cnt - rc0 == 1, "R6", "one read clock pulse", rdclk_cnt - rc0, 1);
      check(rd_latch === ref_mem[a[7:0]], "R6", "read data", rd_latch, ref_mem[a[7:0]]);
      check(!viol_r6, "R6", "read buffer on with RAM output", viol_r6, 0);
    end else begin
      ref_mem[a[7:0]] = wd;
      check(sram_mem[a[7:0]] === wd, "R7", "written data", sram_mem[a[7:0]], wd);
      check(!viol_r7, "R7", "write buffer on with write strobe", viol_r7, 0);
    end
    tick(1);
    memr_ni = 1'b1; memw_ni = 1'b1;
    tick(6);
    check(cpu_tsc_o == 1'b0 && isa_abuf_en_o == 1'b0, "R9", "bus released",
          {cpu_tsc_o, isa_abuf_en_o}, 0);
  endtask

  initial begin
    int wd_cnt = 0;
    while (wd_cnt < 150000) begin @(posedge clk_i); wd_cnt++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = 32'h5eed1;
    bit saw;
    for (int i = 0; i < 256; i++) begin
      sram_mem[i] = 8'(i * 7 + 3);
      ref_mem[i]  = 8'(i * 7 + 3);
    end
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    check({cpu_tsc_o, isa_abuf_en_o, rd_buf_clk_o} == 3'b000, "R10", "reset controls low",
          {cpu_tsc_o, isa_abuf_en_o, rd_buf_clk_o}, 0);
    check({sram_ce_no, sram_oe_no, sram_we_no, rd_buf_oe_no, wr_buf_oe_no, iochrdy_o} == 6'h3f,
          "R10", "reset strobes idle",
          {sram_ce_no, sram_oe_no, sram_we_no, rd_buf_oe_no, wr_buf_oe_no, iochrdy_o}, 6'h3f);

    // R1: strobe outside the window
    isa_addr_i = 20'hC8010; memr_ni = 1'b0;
    saw = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (!iochrdy_o || cpu_tsc_o) saw = 1;
    end
    check(!saw, "R1", "no stall outside window", saw, 0);
    tick(1); memr_ni = 1'b1; tick(2);

    // R3: strobe blip caught by a single clock edge
    @(negedge clk_i); #3;
    isa_addr_i = 20'hD0040; memw_ni = 1'b0;
    @(posedge clk_i); #2;
    memw_ni = 1'b1;
    saw = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk_i);
      if (cpu_tsc_o) saw = 1;
    end
    check(!saw, "R3", "blip starts no request", saw, 0);

    // directed: window edges, read after write, back-to-back
    do_access(20'hD0000, 1'b1, 8'h00);
    do_access(20'hD7FFF, 1'b0, 8'hA5);
    do_access(20'hD7FFF, 1'b1, 8'h00);
    do_access(20'hD0012, 1'b0, 8'h00);
    do_access(20'hD0012, 1'b1, 8'h00);

    for (int i = 0; i < 40; i++) begin
      logic [19:0] a;
      bit rd;
      a  = {5'b11010, 15'($urandom(seed))};
      seed = seed + 1;
      rd = 1'($urandom());
      tick(int'($urandom() % 12));
      do_access(a, rd, 8'($urandom()));
      check(in_window(a), "R1", "random address in window", a, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule